// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

A synchronous model of a battery-free nonvolatile static RAM. A byte-wide working array serves ordinary reads and writes, and a shadow array of the same size holds the nonvolatile copy. Four active-low controls are registered once per clock: chip enable `ce_n`, output enable `oe_n`, write enable `we_n` and nonvolatile enable `ne_n`. Their registered values decode to idle, read, write, store (working array into shadow) or recall (shadow into working array).

Store and recall are timed copies that start only when the controls move into the matching state. While a copy runs, `busy` is high, the data output is released and every input is ignored. A rising `vcc_ok` starts an automatic recall that blocks access for a restore interval. A store requested while `vcc_ok` is low has no effect.

The working array has `2**ADDR_W` bytes. A full-size part uses ADDR_W = 13, which gives 8192 bytes. The default is smaller so that simulation stays light.

Top module: `nvsram_ctrl`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `we_n`=1 and `ne_n`=1 sampled while idle, `dout_en` is 1 and `dout` shows the working byte at the sampled address. A new address shows up one clock after it is sampled, with no control toggle.
- R2: `ce_n`=0, `we_n`=0 and `ne_n`=1 decode a write. The byte is committed when the write ends, that is when `ce_n` or `we_n` is sampled high. It uses the address and data sampled in the last write cycle.
- R3: During a write, `dout_en` is 0 even when `oe_n` is low.
- R4: `ce_n`=0, `we_n`=0, `ne_n`=0 and `oe_n`=1 decode a store. Entering this state starts a store. `busy` is high for exactly STORE_CYC cycles, and at the end the shadow array holds a copy of the working array.
- R5: `ce_n`=0, `oe_n`=0, `ne_n`=0 and `we_n`=1 decode a recall. Entering this state starts a recall. `busy` is high for exactly RECALL_CYC cycles, after which the working array equals the shadow array. The shadow array is unchanged.
- R6: If the store or recall state is still held when a cycle completes, no second cycle starts. A new cycle needs the controls to leave that state and come back.
- R7: While `busy` is 1, `dout_en` is 0, `dout` is 0, and writes presented on the inputs are ignored.
- R8: If the controls already encode a read when a cycle completes, `dout_en` is 1 in the first cycle after `busy` falls.
- R9: A rising `vcc_ok` starts a recall. `busy` is high for RESTORE_CYC cycles, and the working array then equals the shadow array.
- R10: A store requested while `vcc_ok` is low does not start and does not change the shadow array.
- R11: After reset, `busy`, `dout_en` and `dout` are all 0. `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vcc_ok | input | 1 | Supply-good indication |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ne_n | input | 1 | Nonvolatile enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_en | output | 1 | Output drive enable |
| busy | output | 1 | Store, recall or restore in progress |

## Verification
The assertions check on every cycle that the busy counter counts down without a jump (R4) and that every cycle start follows a change in the decoded state or a supply rise (R6). They also check that no store starts without supply (R10), that the working array stays frozen during a store (R7), and that the shadow array stays frozen during a recall (R5). Only the bench scenarios can show the data effects: a write commits at its end, a recall returns stored bytes after the working array has been overwritten, and a write attempted during a recall is lost. The same holds for the exact busy lengths, for the output turning on when a copy completes, and for the ignored low-supply store, which shows up as old data after the next power-up recall.

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int STORE_CYC   = 1000,
  parameter int RECALL_CYC  = 200,
  parameter int RESTORE_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcc_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ne_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (STORE_CYC > RECALL_CYC) ?
                         ((STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC) :
                         ((RECALL_CYC > RESTORE_CYC) ? RECALL_CYC : RESTORE_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {OP_IDLE, OP_READ, OP_WRITE, OP_STORE, OP_RECALL} op_t;
  typedef enum logic [1:0] {M_IDLE, M_STORE, M_RECALL} mode_t;

  logic [DATA_W-1:0] work   [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  logic              ce_q, oe_q, we_q, ne_q, vcc_q, vcc_p;
  logic [ADDR_W-1:0] addr_q, wr_addr;
  logic [DATA_W-1:0] din_q, wr_data;
  logic              wr_pend;
  op_t               op, prev_op;
  mode_t             mode;
  logic [CNT_W-1:0]  cnt;
  logic              pwr_rise, store_go, recall_go;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {ce_q, oe_q, we_q, ne_q} <= 4'hF;
      {vcc_q, vcc_p}           <= 2'b00;
      addr_q  <= '0;
      din_q   <= '0;
      prev_op <= OP_IDLE;
    end else begin
      {ce_q, oe_q, we_q, ne_q} <= {ce_n, oe_n, we_n, ne_n};
      {vcc_q, vcc_p}           <= {vcc_ok, vcc_q};
      addr_q  <= addr;
      din_q   <= din;
      prev_op <= op;
    end

  always_comb begin
    op = OP_IDLE;
    if (!ce_q) begin
      if (ne_q && !we_q)              op = OP_WRITE;
      else if (ne_q && !oe_q)         op = OP_READ;
      else if (!ne_q && !we_q && oe_q) op = OP_STORE;
      else if (!ne_q && we_q && !oe_q) op = OP_RECALL;
    end
  end

  assign pwr_rise  = vcc_q && !vcc_p;
  assign store_go  = (op == OP_STORE)  && (prev_op != OP_STORE) && vcc_q;
  assign recall_go = (op == OP_RECALL) && (prev_op != OP_RECALL);
  assign busy      = (mode != M_IDLE);
  assign dout_en   = !busy && (op == OP_READ);
  assign dout      = dout_en ? work[addr_q] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode    <= M_IDLE;
      cnt     <= '0;
      wr_pend <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
    end else if (pwr_rise) begin
      wr_pend <= 1'b0;
      mode    <= M_RECALL;
      cnt     <= CNT_W'(RESTORE_CYC - 1);
      for (int i = 0; i < DEPTH; i++) work[i] <= '0;
    end else if (mode == M_IDLE) begin
      if (wr_pend && op != OP_WRITE) work[wr_addr] <= wr_data;
      wr_pend <= (op == OP_WRITE);
      if (op == OP_WRITE) begin
        wr_addr <= addr_q;
        wr_data <= din_q;
      end
      if (store_go) begin
        mode <= M_STORE;
        cnt  <= CNT_W'(STORE_CYC - 1);
        for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
      end else if (recall_go) begin
        mode <= M_RECALL;
        cnt  <= CNT_W'(RECALL_CYC - 1);
        for (int i = 0; i < DEPTH; i++) work[i] <= '0;
      end
    end else begin
      wr_pend <= 1'b0;
      if (cnt == '0) begin
        mode <= M_IDLE;
        if (mode == M_STORE) for (int i = 0; i < DEPTH; i++) shadow[i] <= work[i];
        else                 for (int i = 0; i < DEPTH; i++) work[i]   <= shadow[i];
      end else begin
        cnt <= cnt - 1'b1;
      end
    end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && !pwr_rise) |=> (busy && cnt == $past(cnt) - 1'b1)); // R4
  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(op) != $past(prev_op)) || $past(pwr_rise)); // R6
  AST_STORE_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && mode == M_STORE) |-> $past(vcc_q)); // R10
  AST_WORK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STORE && !pwr_rise) |=> $stable(work[0])); // R7
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RECALL) |=> $stable(shadow[0])); // R5
endmodule

// File: tb/nvsram_ctrl_test.sv
module nvsram_ctrl_test;
  localparam int PERIOD = 10;
  localparam int AW = 4, DW = 8, DEPTH = 16;
  localparam int SC = 20, RC = 12, PC = 30;

  logic clk = 0, rst_n = 0, vcc_ok = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, ne_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy;

  logic [DW-1:0] exp_work [DEPTH];
  logic [DW-1:0] exp_shadow [DEPTH];
  int nvec = 0, nerr = 0;
  bit done = 0;

  nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SC), .RECALL_CYC(RC),
                .RESTORE_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .ne_n(ne_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .busy(busy));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int expv);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic set_ctl(logic c, logic o, logic w, logic n);
    ce_n = c; oe_n = o; we_n = w; ne_n = n;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); addr = AW'(a); din = DW'(d); set_ctl(0, 1, 0, 1);
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    exp_work[a] = DW'(d);
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk); addr = AW'(a); set_ctl(0, 0, 1, 1);
    @(negedge clk);
    chk(dout_en === 1'b1 && dout === exp_work[a], tag, int'(dout), int'(exp_work[a]));
  endtask

  task automatic wait_busy(output int n, output int leak);
    n = 0; leak = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (busy) begin
        n++;
        if (dout_en !== 1'b0 || dout !== '0) leak++;
      end else if (n > 0) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy === 0 && dout_en === 0 && dout === '0, "R11 reset state",
        int'({busy, dout_en, dout}), 0);
  endtask

  task automatic t_powerup(string tag);
    int n, lk;
    @(negedge clk); vcc_ok = 1;
    wait_busy(n, lk);
    chk(n == PC, {tag, " R9 restore length"}, n, PC);
    for (int i = 0; i < DEPTH; i++) exp_work[i] = exp_shadow[i];
  endtask

  task automatic t_rw();
    for (int i = 0; i < 8; i++) wr(i, 8'h10 + i * 7);
    rd(3, "R2 write commit");
    @(negedge clk); addr = 0; set_ctl(0, 0, 1, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); addr = AW'(i);
      @(negedge clk);
      chk(dout_en === 1 && dout === exp_work[i], "R1 read follows address",
          int'(dout), int'(exp_work[i]));
    end
    @(negedge clk); set_ctl(1, 1, 1, 1);
  endtask

  task automatic t_write_oe_low();
    @(negedge clk); addr = 9; din = 8'hA5; set_ctl(0, 0, 0, 1);
    @(negedge clk);
    chk(dout_en === 0 && dout === '0, "R3 outputs off in write", int'(dout_en), 0);
    we_n = 1; oe_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    exp_work[9] = 8'hA5;
    rd(9, "R2 write with oe low");
    @(negedge clk); set_ctl(1, 1, 1, 1);
  endtask

  task automatic t_store_recall();
    int n, lk;
    @(negedge clk); set_ctl(0, 1, 0, 0);
    wait_busy(n, lk);
    chk(n == SC, "R4 store length", n, SC);
    chk(lk == 0, "R7 outputs quiet in store", lk, 0);
    for (int i = 0; i < DEPTH; i++) exp_shadow[i] = exp_work[i];
    n = 0;
    repeat (SC + 5) begin @(negedge clk); if (busy) n++; end
    chk(n == 0, "R6 held store no retrigger", n, 0);
    @(negedge clk); set_ctl(1, 1, 1, 1);
    for (int i = 0; i < 8; i++) wr(i, 8'hC0 + i);
    rd(2, "R2 overwrite");
    @(negedge clk); set_ctl(0, 0, 1, 0);
    wait_busy(n, lk);
    chk(n == RC, "R5 recall length", n, RC);
    chk(lk == 0, "R7 outputs quiet in recall", lk, 0);
    n = 0;
    repeat (RC + 5) begin @(negedge clk); if (busy) n++; end
    chk(n == 0, "R6 held recall no retrigger", n, 0);
    for (int i = 0; i < DEPTH; i++) exp_work[i] = exp_shadow[i];
    rd(0, "R5 recall restores byte 0");
    rd(5, "R5 recall restores byte 5");
    rd(9, "R5 recall restores byte 9");
    @(negedge clk); set_ctl(1, 1, 1, 1);
  endtask

  task automatic t_ignore_in_recall();
    int n, lk;
    @(negedge clk); set_ctl(0, 0, 1, 0);
    @(negedge clk);
    @(negedge clk); addr = 4; din = 8'h5A; set_ctl(0, 1, 0, 1);
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    wait_busy(n, lk);
    rd(4, "R7 write during recall ignored");
    @(negedge clk); set_ctl(1, 1, 1, 1);
  endtask

  task automatic t_read_at_end();
    int n, lk;
    wr(6, 8'h66);
    @(negedge clk); set_ctl(0, 1, 0, 0);
    @(negedge clk); addr = 6; set_ctl(0, 0, 1, 1);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (busy) n++;
      else if (n > 0) break;
    end
    chk(dout_en === 1 && dout === 8'h66, "R8 read active at completion",
        int'(dout), 8'h66);
    for (int i = 0; i < DEPTH; i++) exp_shadow[i] = exp_work[i];
    @(negedge clk); set_ctl(1, 1, 1, 1);
  endtask

  task automatic t_low_vcc_store();
    int n;
    wr(3, 8'h77);
    @(negedge clk); vcc_ok = 0;
    @(negedge clk);
    @(negedge clk); set_ctl(0, 1, 0, 0);
    n = 0;
    repeat (SC + 4) begin @(negedge clk); if (busy) n++; end
    chk(n == 0, "R10 store blocked without supply", n, 0);
    @(negedge clk); set_ctl(1, 1, 1, 1);
    t_powerup("second power-up");
    rd(3, "R10 shadow unchanged by blocked store");
    rd(6, "R9 power-up recall restores data");
    @(negedge clk); set_ctl(1, 1, 1, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin exp_work[i] = '0; exp_shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_powerup("first power-up");
    rd(1, "R9 blank after first recall");
    t_rw();
    t_write_oe_low();
    t_store_recall();
    t_ignore_in_recall();
    t_read_at_end();
    t_low_vcc_store();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule